// File: doc/BRIEF.md
# Delay-Triggered ADC Pre-Trigger Channel

This block is one channel of a programmable delay unit. An external free-running counter supplies its value and a wrap strobe. The channel holds one delay per pre-trigger. When the counter first equals an enabled pre-trigger's active delay, the channel sends that pre-trigger to its ADC as a single-clock pulse. The ADC takes one conversion at a time. A pre-trigger that arrives while the converter is still working on an earlier one is dropped, and a sticky error flag is raised for that pre-trigger.

Delays are double-buffered. A bus write lands in a shadow copy. Software then arms a load request, and the shadow copies move into the active compare registers at the next counter wrap. Reads of a delay always return the active value.

Two state machines drive the block:
- Load machine: `LOAD_IDLE` goes to `LOAD_ARMED` on a load request write. `LOAD_ARMED` goes back to `LOAD_IDLE` on a counter wrap, which also performs the copy.
- Conversion machine: `CONV_IDLE` goes to `CONV_BUSY` on an accepted pre-trigger. `CONV_BUSY` goes back to `CONV_IDLE` on `adc_done`.

Register map (word address on `bus_addr`):
- 0 is control: bit 0 is the load request, bits 2:1 are the pre-trigger enables.
- 1 is status: bits 1:0 are the error flags.
- 2 is the delay for pre-trigger 0.
- 3 is the delay for pre-trigger 1.

Top module: `dly_pretrig_chan`

## Requirements
- R1: After reset, all four registers read zero, `pretrig_o` is 0 and `conv_busy` is 0.
- R2: A delay register keeps bits 15:0 of a write. Its bits 31:16 always read zero and ignore written data.
- R3: A write to a delay register does not change the value read back from that register, and does not change the compare value, until a load takes place.
- R4: Writing 1 to control bit 0 makes that bit read 1. At the first counter wrap strictly after the write, every shadow delay is copied to its active register and bit 0 returns to 0. The active value changes at no other time.
- R5: When an enabled pre-trigger's active delay first equals `cnt_val` and the converter is idle, `pretrig_o[m]` pulses high for exactly one clock. The pulse appears on the clock edge that sampled the match.
- R6: A pre-trigger whose enable bit (control bit m+1) is 0 never pulses and never sets its error flag.
- R7: An accepted pre-trigger raises `conv_busy` on the same edge as its pulse. `conv_busy` stays high until the edge that samples `adc_done` high, and falls on that edge.
- R8: A pre-trigger match that occurs while `conv_busy` is high produces no pulse. Status bit m is set on the following edge.
- R9: If both pre-triggers match in the same cycle while the converter is idle, pre-trigger 0 is forwarded, pre-trigger 1 is rejected and status bit 1 is set.
- R10: Writing 0 to status bit m clears that flag. Writing 1 leaves it unchanged. A set and a clear in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | 16 | Current value of the shared delay counter |
| cnt_wrap | input | 1 | High in the last count of a counter cycle |
| adc_done | input | 1 | Conversion-complete strobe from the ADC |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| pretrig_o | output | 2 | Pre-trigger pulses toward the ADC |
| conv_busy | output | 1 | A forwarded conversion is in progress |

## Verification
- A pre-trigger pulse and the rise of `conv_busy` are due one edge after the match cycle, and the bench samples them 1 ns after that edge. At that point `cnt_val` still holds the matched count, so each scoreboard item stores the expected mask and the count at which it must appear.
- Error flags and load completion are due one edge after the rejected match or the wrap. Register readback is combinational, so the bench checks it 1 ns after driving the address.
- The same-cycle set-and-clear case is aligned by waiting for the count just before the match and then issuing the clear write. That write is sampled on the same edge as the rejected match.

// File: rtl/pretrig_pkg.sv
package pretrig_pkg;
    localparam int ADDR_CTRL     = 0;
    localparam int ADDR_STAT     = 1;
    localparam int ADDR_DLY_BASE = 2;

    typedef enum logic {
        LOAD_IDLE,
        LOAD_ARMED
    } load_state_t;

    typedef enum logic {
        CONV_IDLE,
        CONV_BUSY
    } conv_state_t;
endpackage

// File: rtl/pretrig_cmp.sv
module pretrig_cmp #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DLY_W-1:0] cnt_val,
    input  logic [DLY_W-1:0] dly,
    output logic             hit
);
    logic match_now;
    logic match_d;

    assign match_now = en && (cnt_val == dly);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) match_d <= 1'b0;
        else        match_d <= match_now;
    end

    // first cycle of a match only
    assign hit = match_now && !match_d;
endmodule

// File: rtl/pretrig_dly_bank.sv
module pretrig_dly_bank
    import pretrig_pkg::*;
#(
    parameter int N_PRE = 2,
    parameter int DLY_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_PRE-1:0]            shad_we,
    input  logic [DLY_W-1:0]            shad_wdata,
    input  logic                        ldok_set,
    input  logic                        cnt_wrap,
    output logic [N_PRE-1:0][DLY_W-1:0] act_dly,
    output logic                        ldok_pend
);
    load_state_t                 ld_state;
    load_state_t                 ld_next;
    logic [N_PRE-1:0][DLY_W-1:0] shad_q;
    logic                        xfer;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ld_state <= LOAD_IDLE;
        else        ld_state <= ld_next;
    end

    always_comb begin
        ld_next = ld_state;
        unique case (ld_state)
            LOAD_IDLE:  if (ldok_set) ld_next = LOAD_ARMED;
            LOAD_ARMED: if (cnt_wrap && !ldok_set) ld_next = LOAD_IDLE;
            default:    ld_next = LOAD_IDLE;
        endcase
    end

    assign xfer      = (ld_state == LOAD_ARMED) && cnt_wrap;
    assign ldok_pend = (ld_state == LOAD_ARMED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shad_q  <= '0;
            act_dly <= '0;
        end else begin
            for (int i = 0; i < N_PRE; i++) begin
                if (shad_we[i]) shad_q[i] <= shad_wdata;
            end
            if (xfer) act_dly <= shad_q;
        end
    end
endmodule

// File: rtl/pretrig_seq_guard.sv
module pretrig_seq_guard
    import pretrig_pkg::*;
#(
    parameter int N_PRE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_PRE-1:0] hit,
    input  logic             adc_done,
    input  logic             clr_we,
    input  logic [N_PRE-1:0] clr_wdata,
    output logic [N_PRE-1:0] pretrig_o,
    output logic             conv_busy,
    output logic [N_PRE-1:0] err_q
);
    conv_state_t      cv_state;
    conv_state_t      cv_next;
    logic [N_PRE-1:0] grant;
    logic [N_PRE-1:0] reject;
    logic [N_PRE-1:0] clr_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cv_state <= CONV_IDLE;
        else        cv_state <= cv_next;
    end

    always_comb begin
        cv_next = cv_state;
        grant   = '0;
        reject  = hit;
        unique case (cv_state)
            CONV_IDLE: begin
                // lowest-index hit wins
                grant  = hit & (~hit + 1'b1);
                reject = hit & ~grant;
                if (|hit) cv_next = CONV_BUSY;
            end
            CONV_BUSY: begin
                if (adc_done) cv_next = CONV_IDLE;
            end
            default: cv_next = CONV_IDLE;
        endcase
    end

    assign clr_mask  = clr_we ? ~clr_wdata : '0;
    assign conv_busy = (cv_state == CONV_BUSY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pretrig_o <= '0;
            err_q     <= '0;
        end else begin
            pretrig_o <= grant;
            err_q     <= (err_q & ~clr_mask) | reject;
        end
    end
endmodule

// File: rtl/dly_pretrig_chan.sv
module dly_pretrig_chan
    import pretrig_pkg::*;
#(
    parameter int N_PRE  = 2,
    parameter int DLY_W  = 16,
    parameter int BUS_AW = 3,
    parameter int BUS_DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DLY_W-1:0]  cnt_val,
    input  logic              cnt_wrap,
    input  logic              adc_done,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic [N_PRE-1:0]  pretrig_o,
    output logic              conv_busy
);
    localparam logic [BUS_AW-1:0] A_CTRL = BUS_AW'(ADDR_CTRL);
    localparam logic [BUS_AW-1:0] A_STAT = BUS_AW'(ADDR_STAT);

    logic [N_PRE-1:0]            en_q;
    logic [N_PRE-1:0]            err_flags;
    logic [N_PRE-1:0]            hit;
    logic [N_PRE-1:0]            shad_we;
    logic [N_PRE-1:0][DLY_W-1:0] act_dly;
    logic                        ldok_pend;
    logic                        ctrl_wr;
    logic                        stat_wr;
    logic                        unused_wdata_hi;

    assign ctrl_wr         = bus_wr && (bus_addr == A_CTRL);
    assign stat_wr         = bus_wr && (bus_addr == A_STAT);
    assign unused_wdata_hi = ^bus_wdata[BUS_DW-1:DLY_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       en_q <= '0;
        else if (ctrl_wr) en_q <= bus_wdata[N_PRE:1];
    end

    for (genvar g = 0; g < N_PRE; g++) begin : g_pre
        assign shad_we[g] = bus_wr && (bus_addr == BUS_AW'(ADDR_DLY_BASE + g));

        pretrig_cmp #(.DLY_W(DLY_W)) u_cmp (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (en_q[g]),
            .cnt_val (cnt_val),
            .dly     (act_dly[g]),
            .hit     (hit[g])
        );
    end

    pretrig_dly_bank #(.N_PRE(N_PRE), .DLY_W(DLY_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .shad_we    (shad_we),
        .shad_wdata (bus_wdata[DLY_W-1:0]),
        .ldok_set   (ctrl_wr && bus_wdata[0]),
        .cnt_wrap   (cnt_wrap),
        .act_dly    (act_dly),
        .ldok_pend  (ldok_pend)
    );

    pretrig_seq_guard #(.N_PRE(N_PRE)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .adc_done  (adc_done),
        .clr_we    (stat_wr),
        .clr_wdata (bus_wdata[N_PRE-1:0]),
        .pretrig_o (pretrig_o),
        .conv_busy (conv_busy),
        .err_q     (err_flags)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL) begin
            bus_rdata[0]       = ldok_pend;
            bus_rdata[N_PRE:1] = en_q;
        end
        if (bus_addr == A_STAT) bus_rdata[N_PRE-1:0] = err_flags;
        for (int i = 0; i < N_PRE; i++) begin
            if (bus_addr == BUS_AW'(ADDR_DLY_BASE + i)) bus_rdata[DLY_W-1:0] = act_dly[i];
        end
    end
endmodule

// File: rtl/dly_pretrig_chan_chk.sv
module dly_pretrig_chan_chk
    import pretrig_pkg::*;
#(
    parameter int N_PRE  = 2,
    parameter int DLY_W  = 16,
    parameter int BUS_AW = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cnt_wrap,
    input logic                        adc_done,
    input logic                        bus_wr,
    input logic [BUS_AW-1:0]           bus_addr,
    input logic [N_PRE-1:0]            bus_wdata_lo,
    input logic [N_PRE-1:0]            pretrig_o,
    input logic                        conv_busy,
    input logic [N_PRE-1:0]            en_q,
    input logic [N_PRE-1:0]            err_q,
    input logic [N_PRE-1:0][DLY_W-1:0] act_dly
);
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pretrig_o)); // R9
    AST_FIRE_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (|pretrig_o) |-> conv_busy); // R7
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_busy && adc_done) |=> !conv_busy); // R7
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        conv_busy |=> !(|pretrig_o)); // R8
    AST_ACTIVE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_dly) |-> $past(cnt_wrap)); // R4

    for (genvar m = 0; m < N_PRE; m++) begin : g_m
        AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            pretrig_o[m] |=> !pretrig_o[m]); // R5
        AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            pretrig_o[m] |-> $past(en_q[m])); // R6
        AST_ERR_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(err_q[m]) |-> $past(bus_wr && (bus_addr == BUS_AW'(ADDR_STAT)) && !bus_wdata_lo[m])); // R10
    end
endmodule

bind dly_pretrig_chan dly_pretrig_chan_chk #(.N_PRE(N_PRE), .DLY_W(DLY_W), .BUS_AW(BUS_AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_wrap     (cnt_wrap),
    .adc_done     (adc_done),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata_lo (bus_wdata[N_PRE-1:0]),
    .pretrig_o    (pretrig_o),
    .conv_busy    (conv_busy),
    .en_q         (en_q),
    .err_q        (err_flags),
    .act_dly      (act_dly)
);

// File: tb/dly_pretrig_chan_tb.sv
`timescale 1ns/100ps
module dly_pretrig_chan_tb;
    localparam int CYC_LEN = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_val = '0;
    logic        cnt_wrap;
    logic        adc_done = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  pretrig_o;
    logic        conv_busy;
    bit          run = 0;
    bit          auto_done = 0;

    typedef struct {
        logic [1:0]  mask;
        logic [15:0] at;
    } exp_t;
    exp_t sbq[$];
    int   n_chk = 0;
    int   n_err = 0;

    always #2.5 clk = ~clk;

    assign cnt_wrap = run && (cnt_val == 16'(CYC_LEN - 1));

    dly_pretrig_chan u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_val   (cnt_val),
        .cnt_wrap  (cnt_wrap),
        .adc_done  (adc_done),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pretrig_o (pretrig_o),
        .conv_busy (conv_busy)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic bus_write(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read_check(string req, logic [2:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic wait_cnt(logic [15:0] v);
        do begin
            @(posedge clk); #1;
        end while (cnt_val != v);
    endtask

    task automatic wait_load_done();
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            bus_addr = 3'd0;
            #1;
            if (bus_rdata[0] == 1'b0) break;
        end
    endtask

    task automatic expect_pulse(logic [1:0] mask, logic [15:0] at);
        exp_t e;
        e.mask = mask;
        e.at   = at;
        sbq.push_back(e);
    endtask

    // counter model
    initial forever begin
        @(negedge clk);
        if (run) cnt_val = cnt_wrap ? 16'd0 : cnt_val + 16'd1;
    end

    // scoreboard monitor
    initial forever begin
        @(posedge clk); #1;
        if (rst_n && pretrig_o != 2'b00) begin
            if (sbq.size() == 0) begin
                check("R5 unexpected pulse", 32'(pretrig_o), 32'd0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check("R5 pulse mask", 32'(pretrig_o), 32'(e.mask));
                check("R5 pulse count", 32'(cnt_val), 32'(e.at));
            end
        end
    end

    // ADC completion responder
    initial forever begin
        @(posedge clk); #1;
        if (pretrig_o != 2'b00 && auto_done) begin
            @(negedge clk);
            @(negedge clk);
            adc_done = 1'b1;
            @(negedge clk);
            adc_done = 1'b0;
        end
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        bus_read_check("R1 ctrl", 3'd0, 32'd0);
        bus_read_check("R1 stat", 3'd1, 32'd0);
        bus_read_check("R1 dly0", 3'd2, 32'd0);
        bus_read_check("R1 dly1", 3'd3, 32'd0);
        check("R1 pretrig", 32'(pretrig_o), 32'd0);
        check("R1 busy", 32'(conv_busy), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        run   = 1;

        // R2 R3 R4 buffered load
        bus_write(3'd2, 32'hABCD_0005);
        bus_write(3'd3, 32'd12);
        bus_read_check("R3 dly0 still active value", 3'd2, 32'd0);
        bus_write(3'd0, 32'd1);
        bus_read_check("R4 load pending", 3'd0, 32'd1);
        wait_cnt(16'd2);
        bus_read_check("R4 load done", 3'd0, 32'd0);
        bus_read_check("R2 dly0 upper zero", 3'd2, 32'h0000_0005);
        bus_read_check("R4 dly1 loaded", 3'd3, 32'd12);

        // R5 both pre-triggers, ADC completes between them
        auto_done = 1;
        wait_cnt(16'd20);
        bus_write(3'd0, 32'd6);
        expect_pulse(2'b01, 16'd5);
        expect_pulse(2'b10, 16'd12);
        wait_cnt(16'd20);
        bus_write(3'd0, 32'd0);
        check("R5 all pulses seen", 32'(sbq.size()), 32'd0);
        bus_read_check("R8 no error when idle", 3'd1, 32'd0);

        // R7 R8 R10 collision with clear in same cycle
        auto_done = 0;
        wait_cnt(16'd20);
        bus_write(3'd0, 32'd6);
        expect_pulse(2'b01, 16'd5);
        wait_cnt(16'd6);
        check("R7 busy after accept", 32'(conv_busy), 32'd1);
        wait_cnt(16'd11);
        bus_write(3'd1, 32'd0);
        wait_cnt(16'd20);
        bus_write(3'd0, 32'd0);
        bus_read_check("R8 R10 err1 set, set beats clear", 3'd1, 32'd2);
        check("R7 busy held", 32'(conv_busy), 32'd1);
        @(negedge clk);
        adc_done = 1'b1;
        @(negedge clk);
        adc_done = 1'b0;
        check("R7 busy released", 32'(conv_busy), 32'd0);
        bus_write(3'd1, 32'd2);
        bus_read_check("R10 write one keeps", 3'd1, 32'd2);
        bus_write(3'd1, 32'd0);
        bus_read_check("R10 write zero clears", 3'd1, 32'd0);

        // R9 simultaneous match
        auto_done = 1;
        bus_write(3'd2, 32'd9);
        bus_write(3'd3, 32'd9);
        bus_write(3'd0, 32'd1);
        wait_load_done();
        wait_cnt(16'd20);
        bus_write(3'd0, 32'd6);
        expect_pulse(2'b01, 16'd9);
        wait_cnt(16'd20);
        bus_write(3'd0, 32'd0);
        bus_read_check("R9 higher index rejected", 3'd1, 32'd2);
        bus_write(3'd1, 32'd0);

        // R6 pre-trigger 0 disabled
        wait_cnt(16'd20);
        bus_write(3'd0, 32'd4);
        expect_pulse(2'b10, 16'd9);
        wait_cnt(16'd20);
        bus_write(3'd0, 32'd0);
        bus_read_check("R6 disabled sets no error", 3'd1, 32'd0);

        // R4 new delay only after wrap
        wait_cnt(16'd20);
        bus_write(3'd2, 32'd3);
        bus_write(3'd0, 32'd3);
        bus_read_check("R3 old value until wrap", 3'd2, 32'd9);
        expect_pulse(2'b01, 16'd3);
        wait_cnt(16'd8);
        bus_read_check("R4 new value after wrap", 3'd2, 32'd3);
        bus_read_check("R4 load flag cleared", 3'd0, 32'd2);
        bus_write(3'd0, 32'd0);
        repeat (4) @(negedge clk);
        check("R5 scoreboard drained", 32'(sbq.size()), 32'd0);
        summary();
    end
endmodule